// File: doc/BRIEF.md
# Poison-Tagged Speculative Register File

This block is a multi-ported register file in which every register carries a one-bit poison tag. It lets a compiler hoist instructions above branches without changing which programs fault. A speculative instruction that hits a terminating exception, such as a protection violation, does not trap. Its destination is tagged instead. The trap is raised later, and only if a normal instruction reads that register as a source. Recoverable exceptions, such as page faults, are reported at once whether or not the instruction is speculative, and they never touch the tag.

Each write port carries the result, a speculative flag, a terminating-exception flag, a recoverable-exception flag and a source-poisoned flag. The pipeline sets the source-poisoned flag from the poison outputs it saw when it read the instruction's operands. Each read port carries an enable, an address and a speculative flag. Read data, poison state and the deferred fault are combinational from the stored state. A write becomes visible from the cycle after its clock edge, and there is no write-to-read bypass. Register 0 always reads as zero.

Top module: `psn_regfile`

## Requirements
- R1: While rst_ni is low, every register reads data 0 and poison 0. The reset is asynchronous and active low.
- R2: A write with wr_spec_i=0 and no exception stores wr_data_i and clears the poison tag of its destination. The new value is visible on reads from the cycle after the clock edge.
- R3: A speculative write (wr_spec_i=1) with wr_term_i=1 and wr_recov_i=0 stores its data and sets the poison tag of its destination. exc_now_o for that port stays 0.
- R4: A non-speculative write with wr_term_i=1 and wr_recov_i=0 asserts exc_now_o for its port in the same cycle and leaves the destination's data and poison tag unchanged.
- R5: A write with wr_recov_i=1 asserts exc_now_o for its port in the same cycle, whatever its other flags, and leaves the destination's data and poison tag unchanged.
- R6: A speculative write with wr_src_psn_i=1 sets the destination's poison tag even without an exception. A non-speculative write ignores wr_src_psn_i.
- R7: An enabled non-speculative read of a poisoned register asserts rd_fault_o for that port in the same cycle. fault_o is the OR of all rd_fault_o bits. fault_reg_o gives the address read by the lowest-indexed faulting port, and is 0 when there is no fault.
- R8: A speculative read of a poisoned register never faults. It returns the stored data with rd_psn_o=1.
- R9: Register 0 reads data 0 and poison 0, and writes to it have no effect.
- R10: When several write ports commit to the same register in one cycle, the highest-indexed port's data and poison tag are stored.
- R11: A read in the same cycle as a write to the same register returns the value held before that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | NUM_WR | Write request per port |
| wr_addr_i | input | NUM_WR x AW | Destination register per port |
| wr_data_i | input | NUM_WR x DATA_W | Result value per port |
| wr_spec_i | input | NUM_WR | Producing instruction is speculative |
| wr_term_i | input | NUM_WR | Terminating exception on this result |
| wr_recov_i | input | NUM_WR | Recoverable exception on this result |
| wr_src_psn_i | input | NUM_WR | A source of the producing instruction was poisoned |
| exc_now_o | output | NUM_WR | Exception to be taken immediately, per write port |
| rd_en_i | input | NUM_RD | Read is an actual source use |
| rd_addr_i | input | NUM_RD x AW | Source register per port |
| rd_spec_i | input | NUM_RD | Reading instruction is speculative |
| rd_data_o | output | NUM_RD x DATA_W | Read data |
| rd_psn_o | output | NUM_RD | Poison tag of the addressed register |
| rd_fault_o | output | NUM_RD | Deferred fault per read port |
| fault_o | output | 1 | Any read port faulted |
| fault_reg_o | output | AW | Register that raised the deferred fault |

## Verification
The exception flags (exc_now_o) and all read results are combinational. The bench drives stimulus on the falling edge and samples one nanosecond later, in the same cycle and before the next rising edge. Stored effects of a write (data, poison tag, or no change) are due at the rising edge that ends the write cycle. The bench checks them by a read in the following cycle, so that the write and its read-back never share a sample. The same-cycle read against a pending write is sampled before that edge, which is how the missing bypass is checked.

// File: rtl/psn_rf_pkg.sv
package psn_rf_pkg;
  // per-port write decision
  typedef struct packed {
    logic commit;  // update data and tag
    logic psn;     // tag value to store
    logic exc;     // exception to raise now
  } wr_class_t;
endpackage

// File: rtl/psn_rf_wr_class.sv
module psn_rf_wr_class
  import psn_rf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      spec_i,
  input  logic      term_i,
  input  logic      recov_i,
  input  logic      src_psn_i,
  output wr_class_t cls_o
);
  logic trap_now;

  // a terminating fault traps at once only for a normal instruction
  assign trap_now     = term_i & ~spec_i;
  assign cls_o.exc    = en_i & (recov_i | trap_now);
  assign cls_o.commit = en_i & ~recov_i & ~trap_now;
  assign cls_o.psn    = spec_i & (term_i | src_psn_i);

  p_recov_no_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_i |-> !cls_o.commit);
  p_spec_term_no_trap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && spec_i && term_i && !recov_i) |-> (cls_o.commit && cls_o.psn && !cls_o.exc));
endmodule

// File: rtl/psn_rf_store.sv
module psn_rf_store
  import psn_rf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NWR  = 2,
  parameter int AW   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  wr_class_t [NWR-1:0]      cls_i,
  input  logic [NWR-1:0][AW-1:0]   wr_addr_i,
  input  logic [NWR-1:0][DW-1:0]   wr_data_i,
  output logic [NREG-1:0][DW-1:0]  data_o,
  output logic [NREG-1:0]          psn_o
);
  // register 0 is constant
  assign data_o[0] = '0;
  assign psn_o[0]  = 1'b0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic          hit;
    logic [DW-1:0] nxt_data;
    logic          nxt_psn;
    logic [DW-1:0] data_q;
    logic          psn_q;

    // later ports override earlier ones
    always_comb begin
      hit      = 1'b0;
      nxt_data = data_q;
      nxt_psn  = psn_q;
      for (int k = 0; k < NWR; k++) begin
        if (cls_i[k].commit && (wr_addr_i[k] == AW'(r))) begin
          hit      = 1'b1;
          nxt_data = wr_data_i[k];
          nxt_psn  = cls_i[k].psn;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        psn_q  <= 1'b0;
      end else if (hit) begin
        data_q <= nxt_data;
        psn_q  <= nxt_psn;
      end
    end

    assign data_o[r] = data_q;
    assign psn_o[r]  = psn_q;
  end

  p_top_port_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i[NWR-1].commit && wr_addr_i[NWR-1] != '0 && int'(wr_addr_i[NWR-1]) < NREG)
    |=> (data_o[$past(wr_addr_i[NWR-1])] == $past(wr_data_i[NWR-1]))
        && (psn_o[$past(wr_addr_i[NWR-1])] == $past(cls_i[NWR-1].psn)));
  p_clean_write_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i[NWR-1].commit && !cls_i[NWR-1].psn && int'(wr_addr_i[NWR-1]) < NREG)
    |=> !psn_o[$past(wr_addr_i[NWR-1])]);
endmodule

// File: rtl/psn_rf_read.sv
module psn_rf_read #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic                     spec_i,
  input  logic [NREG-1:0][DW-1:0]  data_i,
  input  logic [NREG-1:0]          psn_i,
  output logic [DW-1:0]            data_o,
  output logic                     psn_o,
  output logic                     fault_o
);
  logic in_range;

  assign in_range = int'(addr_i) < NREG;
  assign data_o   = in_range ? data_i[addr_i] : '0;
  assign psn_o    = in_range ? psn_i[addr_i] : 1'b0;
  // deferred trap fires only on a real, non-speculative use
  assign fault_o  = en_i & ~spec_i & psn_o;

  p_spec_read_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_i |-> !fault_o);
  p_zero_reg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (data_o == '0 && !psn_o && !fault_o));
endmodule

// File: rtl/psn_rf_fault.sv
module psn_rf_fault #(
  parameter int NRD = 2,
  parameter int AW  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NRD-1:0]         fault_i,
  input  logic [NRD-1:0][AW-1:0] addr_i,
  output logic                   fault_o,
  output logic [AW-1:0]          fault_reg_o
);
  // lowest-indexed faulting port reports
  always_comb begin
    fault_o     = 1'b0;
    fault_reg_o = '0;
    for (int j = NRD - 1; j >= 0; j--) begin
      if (fault_i[j]) begin
        fault_o     = 1'b1;
        fault_reg_o = addr_i[j];
      end
    end
  end

  p_port0_reports_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[0] |-> (fault_o && fault_reg_o == addr_i[0]));
  p_no_fault_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i == '0) |-> (!fault_o && fault_reg_o == '0));
endmodule

// File: rtl/psn_regfile.sv
module psn_regfile
  import psn_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_RD   = 2,
  parameter int NUM_WR   = 2,
  localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]     wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
  input  logic [NUM_WR-1:0]             wr_spec_i,
  input  logic [NUM_WR-1:0]             wr_term_i,
  input  logic [NUM_WR-1:0]             wr_recov_i,
  input  logic [NUM_WR-1:0]             wr_src_psn_i,
  output logic [NUM_WR-1:0]             exc_now_o,
  input  logic [NUM_RD-1:0]             rd_en_i,
  input  logic [NUM_RD-1:0][AW-1:0]     rd_addr_i,
  input  logic [NUM_RD-1:0]             rd_spec_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o,
  output logic [NUM_RD-1:0]             rd_psn_o,
  output logic [NUM_RD-1:0]             rd_fault_o,
  output logic                          fault_o,
  output logic [AW-1:0]                 fault_reg_o
);
  wr_class_t [NUM_WR-1:0]           cls_w;
  logic [NUM_REGS-1:0][DATA_W-1:0]  data_w;
  logic [NUM_REGS-1:0]              psn_w;

  for (genvar k = 0; k < NUM_WR; k++) begin : g_wr
    psn_rf_wr_class i_class (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (wr_en_i[k]),
      .spec_i    (wr_spec_i[k]),
      .term_i    (wr_term_i[k]),
      .recov_i   (wr_recov_i[k]),
      .src_psn_i (wr_src_psn_i[k]),
      .cls_o     (cls_w[k])
    );
    assign exc_now_o[k] = cls_w[k].exc;

    p_recov_now_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[k] && wr_recov_i[k]) |-> exc_now_o[k]);
    p_normal_term_now_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[k] && wr_term_i[k] && !wr_spec_i[k]) |-> exc_now_o[k]);
  end

  psn_rf_store #(
    .NREG (NUM_REGS),
    .DW   (DATA_W),
    .NWR  (NUM_WR),
    .AW   (AW)
  ) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cls_i     (cls_w),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .data_o    (data_w),
    .psn_o     (psn_w)
  );

  for (genvar j = 0; j < NUM_RD; j++) begin : g_rd
    psn_rf_read #(
      .NREG (NUM_REGS),
      .DW   (DATA_W),
      .AW   (AW)
    ) i_read (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (rd_en_i[j]),
      .addr_i  (rd_addr_i[j]),
      .spec_i  (rd_spec_i[j]),
      .data_i  (data_w),
      .psn_i   (psn_w),
      .data_o  (rd_data_o[j]),
      .psn_o   (rd_psn_o[j]),
      .fault_o (rd_fault_o[j])
    );

    p_fault_flagged_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_fault_o[j] |-> (fault_o && rd_psn_o[j]));
  end

  psn_rf_fault #(
    .NRD (NUM_RD),
    .AW  (AW)
  ) i_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_i     (rd_fault_o),
    .addr_i      (rd_addr_i),
    .fault_o     (fault_o),
    .fault_reg_o (fault_reg_o)
  );
endmodule

// File: tb/test_psn_regfile.sv
module test_psn_regfile;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int NRD = 2;
  localparam int NWR = 2;
  localparam int AW = 3;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NWR-1:0]          wr_en_i, wr_spec_i, wr_term_i, wr_recov_i, wr_src_psn_i;
  logic [NWR-1:0][AW-1:0]  wr_addr_i;
  logic [NWR-1:0][DW-1:0]  wr_data_i;
  logic [NWR-1:0]          exc_now_o;
  logic [NRD-1:0]          rd_en_i, rd_spec_i, rd_psn_o, rd_fault_o;
  logic [NRD-1:0][AW-1:0]  rd_addr_i;
  logic [NRD-1:0][DW-1:0]  rd_data_o;
  logic                    fault_o;
  logic [AW-1:0]           fault_reg_o;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] m_data [NR];
  logic          m_psn  [NR];

  always #HALF clk = ~clk;

  psn_regfile #(.NUM_REGS(NR), .DATA_W(DW), .NUM_RD(NRD), .NUM_WR(NWR)) i_psn_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_spec_i(wr_spec_i), .wr_term_i(wr_term_i), .wr_recov_i(wr_recov_i),
    .wr_src_psn_i(wr_src_psn_i), .exc_now_o(exc_now_o),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_spec_i(rd_spec_i),
    .rd_data_o(rd_data_o), .rd_psn_o(rd_psn_o), .rd_fault_o(rd_fault_o),
    .fault_o(fault_o), .fault_reg_o(fault_reg_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = '0; wr_spec_i = '0; wr_term_i = '0; wr_recov_i = '0; wr_src_psn_i = '0;
    wr_addr_i = '0; wr_data_i = '0;
    rd_en_i = '0; rd_spec_i = '0; rd_addr_i = '0;
  endtask

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      m_data[r] = '0;
      m_psn[r]  = 1'b0;
    end
  endtask

  // expected effect of one write, from R2..R6, R9
  function automatic logic exp_exc(logic s, logic t, logic rc);
    return rc | (t & ~s);
  endfunction

  task automatic model_write(int a, logic [DW-1:0] d, logic s, logic t, logic rc, logic sp);
    if (a != 0 && !exp_exc(s, t, rc)) begin
      m_data[a] = d;
      m_psn[a]  = s & (t | sp);
    end
  endtask

  task automatic set_wr(int p, int a, logic [DW-1:0] d, logic s, logic t, logic rc, logic sp);
    wr_en_i[p] = 1'b1; wr_addr_i[p] = AW'(a); wr_data_i[p] = d;
    wr_spec_i[p] = s; wr_term_i[p] = t; wr_recov_i[p] = rc; wr_src_psn_i[p] = sp;
  endtask

  task automatic wr_step(int p, int a, logic [DW-1:0] d, logic s, logic t, logic rc, logic sp);
    @(negedge clk);
    idle();
    set_wr(p, a, d, s, t, rc, sp);
    #1;
    chk($sformatf("R3/R4/R5 exc_now port%0d s%0d t%0d rc%0d", p, s, t, rc),
        32'(exc_now_o[p]), 32'(exp_exc(s, t, rc)));
    @(posedge clk);
    model_write(a, d, s, t, rc, sp);
  endtask

  // port0 normal use, port1 speculative use of the same register
  task automatic rd_check(int a, string tag);
    @(negedge clk);
    idle();
    rd_en_i = 2'b11; rd_addr_i[0] = AW'(a); rd_addr_i[1] = AW'(a); rd_spec_i = 2'b10;
    #1;
    chk({tag, " R2 data"}, 32'(rd_data_o[0]), 32'(m_data[a]));
    chk({tag, " R8 spec data"}, 32'(rd_data_o[1]), 32'(m_data[a]));
    chk({tag, " R8 psn"}, 32'(rd_psn_o[1]), 32'(m_psn[a]));
    chk({tag, " R7 fault0"}, 32'(rd_fault_o[0]), 32'(m_psn[a]));
    chk({tag, " R8 fault1"}, 32'(rd_fault_o[1]), 32'h0);
    chk({tag, " R7 fault_reg"}, 32'(fault_reg_o), m_psn[a] ? 32'(a) : 32'h0);
  endtask

  initial begin
    #(2 * HALF * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle();
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state on every register
    for (int r = 0; r < NR; r++) begin
      rd_addr_i[0] = AW'(r); rd_en_i = 2'b01;
      #1;
      chk($sformatf("R1 reset data r%0d", r), 32'(rd_data_o[0]), 32'h0);
      chk($sformatf("R1 reset psn r%0d", r), 32'(rd_psn_o[0]), 32'h0);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // sweep: every flag combination on every register, alternating ports
    for (int r = 1; r < NR; r++) begin
      for (int c = 0; c < 16; c++) begin
        wr_step(c % 2, r, DW'(r * 16'h0111 + c * 16'h1003), c[0], c[1], c[2], c[3]);
        rd_check(r, $sformatf("sweep r%0d c%0d", r, c));
      end
    end

    // R9: poisoning write to register 0 has no effect
    wr_step(0, 0, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b0);
    rd_check(0, "R9 zero reg");

    // R10: both ports hit register 3, port1 poisoned result wins
    @(negedge clk);
    idle();
    set_wr(0, 3, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0);
    set_wr(1, 3, 16'h2222, 1'b1, 1'b1, 1'b0, 1'b0);
    @(posedge clk);
    model_write(3, 16'h2222, 1'b1, 1'b1, 1'b0, 1'b0);
    rd_check(3, "R10 collision");
    chk("R10 psn port1 wins", 32'(m_psn[3]), 32'h1);

    // R11: same-cycle read sees the old value
    wr_step(0, 5, 16'h0A0A, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    idle();
    set_wr(1, 5, 16'h5B5B, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_en_i = 2'b01; rd_addr_i[0] = 3'd5;
    #1;
    chk("R11 no bypass", 32'(rd_data_o[0]), 32'h0A0A);
    @(posedge clk);
    model_write(5, 16'h5B5B, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_check(5, "R11 after edge");

    // R7: two faulting ports, port0 address reported
    wr_step(0, 2, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b0);
    wr_step(1, 6, 16'h0006, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    idle();
    rd_en_i = 2'b11; rd_addr_i[0] = 3'd6; rd_addr_i[1] = 3'd2; rd_spec_i = 2'b00;
    #1;
    chk("R7 both fault", 32'(rd_fault_o), 32'h3);
    chk("R7 fault_o", 32'(fault_o), 32'h1);
    chk("R7 lowest port reg", 32'(fault_reg_o), 32'h6);
    rd_en_i = 2'b10;
    #1;
    chk("R7 disabled port0 silent", 32'(rd_fault_o), 32'h2);
    chk("R7 port1 reg", 32'(fault_reg_o), 32'h2);

    // R1: asynchronous reset mid-run clears tags
    @(negedge clk);
    idle();
    rst_ni = 1'b0;
    #1;
    rd_addr_i[0] = 3'd2; rd_addr_i[1] = 3'd6;
    #1;
    chk("R1 async clear r2", 32'(rd_psn_o[0]), 32'h0);
    chk("R1 async clear r6 data", 32'(rd_data_o[1]), 32'h0);
    model_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    rd_check(2, "R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule